// File: doc/BRIEF.md
# Queue Pair Pointer Registers with Coalesced Interrupt

This block keeps the four ring indexes of one channel's queue pair. The host fills a request ring that the device drains, and the device fills a response ring that the host drains. Each side moves only the pointers it owns. The host reaches the pointers through a small register window on a simple select/write/read bus. The device side has three strobes: consume one request, insert one response, and signal that a request has completed.

The block turns each index into an element address from a per-ring base address and a fixed element size. It raises a one-cycle interrupt pulse when the response ring leaves the empty state, so a burst of inserts costs the host one interrupt. A completing request can also carry a force flag. When forcing is enabled, that flag raises the pulse whatever the ring holds.

The depth is a power of two and every index wraps modulo the depth. A ring is empty when its two indexes are equal. The response ring is full when its tail plus one equals its head, so one slot always stays unused. One instance serves one channel; a chip with many channels places one instance in each 4 KB slice of its register space.

Top module: `qpair_ptr_regs`

## Requirements
- R1: After reset all four indexes are zero, `msi_pulse` is 0, `rsp_full` is 0 and `req_avail` is 0.
- R2: A host write to offset 0x4 loads the request tail with `wdata mod DEPTH` at the next clock edge. Reading offset 0x4 returns that value zero-extended to 32 bits. `req_avail` is 1 exactly when the request head differs from the request tail.
- R3: Host writes to offset 0x0 (request head) and offset 0xC (response tail) leave both indexes unchanged.
- R4: `dev_req_consume` advances the request head by one modulo DEPTH when `req_avail` is 1. It has no effect when the request ring is empty.
- R5: A host write to offset 0x8 loads the response head with `wdata mod DEPTH`. Reading offset 0x8 returns it.
- R6: `rsp_full` is 1 exactly when (response tail + 1) mod DEPTH equals the response head. When `rsp_full` is 0, `dev_rsp_insert` advances the response tail by one. When `rsp_full` is 1, the insert is refused and no index moves.
- R7: An accepted insert into an empty response ring produces `msi_pulse` = 1 for exactly the one cycle after the edge. An insert into a non-empty ring produces no pulse.
- R8: `dev_req_done` with `dev_done_force` = 1 and `cfg_force_en` = 1 produces a one-cycle pulse after the edge. If either flag is 0, `dev_req_done` produces no pulse.
- R9: `req_head_addr` equals `req_base + req_head*ELEM_BYTES` and `rsp_tail_addr` equals `rsp_base + rsp_tail*ELEM_BYTES`, combinationally.
- R10: Reads are combinational while `bus_sel`=1 and `bus_wr`=0. Any offset other than 0x0, 0x4, 0x8 or 0xC reads as zero. Reads return zero when no read is selected.
- R11: The empty check uses the ring state before the edge. An insert into an empty ring while the host rewrites the response head yields exactly one pulse. An insert into a non-empty ring while the host drains it in the same cycle yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFS_W | Byte offset within the channel slice |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| req_base | input | AW | Request ring base address |
| rsp_base | input | AW | Response ring base address |
| dev_req_consume | input | 1 | Device takes one request |
| dev_rsp_insert | input | 1 | Device adds one response |
| dev_req_done | input | 1 | A request completed |
| dev_done_force | input | 1 | Completed request carries the force flag |
| cfg_force_en | input | 1 | Enables honouring the force flag |
| req_avail | output | 1 | Request ring not empty |
| rsp_full | output | 1 | Response ring full; insert refused |
| req_head_addr | output | AW | Address of the next request to consume |
| rsp_tail_addr | output | AW | Address of the next response slot |
| msi_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
Reads, `req_avail`, `rsp_full` and both element addresses are combinational, so the bench checks them in the same cycle as the stimulus, one time unit after the inputs settle. Index updates and `msi_pulse` take one register. The bench drives each strobe just after a rising edge and samples one time unit after the next rising edge, where the new index and the pulse first appear. It also samples one edge later to confirm that the pulse has cleared. A bench model of the four indexes is advanced arithmetically modulo the depth, and every readback is compared against it.

// File: rtl/qpair_ptr_regs.sv
module qpair_ptr_regs #(
  parameter int DEPTH      = 64,
  parameter int ELEM_BYTES = 64,
  parameter int AW         = 64,
  parameter int OFS_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [AW-1:0]     req_base,
  input  logic [AW-1:0]     rsp_base,
  input  logic              dev_req_consume,
  input  logic              dev_rsp_insert,
  input  logic              dev_req_done,
  input  logic              dev_done_force,
  input  logic              cfg_force_en,
  output logic              req_avail,
  output logic              rsp_full,
  output logic [AW-1:0]     req_head_addr,
  output logic [AW-1:0]     rsp_tail_addr,
  output logic              msi_pulse
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [OFS_W-1:0] OFS_RQH = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_RQT = OFS_W'(4);
  localparam logic [OFS_W-1:0] OFS_RSH = OFS_W'(8);
  localparam logic [OFS_W-1:0] OFS_RST = OFS_W'(12);

  logic [IDX_W-1:0] rq_head, rq_tail, rs_head, rs_tail;

  wire host_wr   = bus_sel & bus_wr;
  wire host_rd   = bus_sel & ~bus_wr;
  wire wr_rqt    = host_wr & (bus_addr == OFS_RQT);
  wire wr_rsh    = host_wr & (bus_addr == OFS_RSH);
  wire rs_empty  = (rs_head == rs_tail);
  wire ins_ok    = dev_rsp_insert & ~rsp_full;
  wire cons_ok   = dev_req_consume & req_avail;
  wire force_hit = dev_req_done & dev_done_force & cfg_force_en;
  wire [IDX_W-1:0] wr_idx = bus_wdata[IDX_W-1:0];
  logic unused_hi;

  assign unused_hi     = ^bus_wdata[31:IDX_W];
  assign req_avail     = (rq_head != rq_tail);
  assign rsp_full      = ((rs_tail + IDX_W'(1)) == rs_head);
  assign req_head_addr = req_base + AW'(rq_head) * AW'(ELEM_BYTES);
  assign rsp_tail_addr = rsp_base + AW'(rs_tail) * AW'(ELEM_BYTES);

  always_comb begin
    bus_rdata = '0;
    if (host_rd) begin
      case (bus_addr)
        OFS_RQH: bus_rdata = 32'(rq_head);
        OFS_RQT: bus_rdata = 32'(rq_tail);
        OFS_RSH: bus_rdata = 32'(rs_head);
        OFS_RST: bus_rdata = 32'(rs_tail);
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_head   <= '0;
      rq_tail   <= '0;
      rs_head   <= '0;
      rs_tail   <= '0;
      msi_pulse <= 1'b0;
    end else begin
      if (cons_ok) rq_head <= rq_head + IDX_W'(1);
      if (wr_rqt)  rq_tail <= wr_idx;
      if (wr_rsh)  rs_head <= wr_idx;
      if (ins_ok)  rs_tail <= rs_tail + IDX_W'(1);
      msi_pulse <= (ins_ok & rs_empty) | force_hit;
    end
  end
endmodule

// File: rtl/qpair_ptr_regs_chk.sv
module qpair_ptr_regs_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [11:0]      addr_lo,
  input logic             dev_req_consume,
  input logic             dev_rsp_insert,
  input logic             dev_req_done,
  input logic             dev_done_force,
  input logic             cfg_force_en,
  input logic             req_avail,
  input logic             rsp_full,
  input logic [IDX_W-1:0] rq_head,
  input logic [IDX_W-1:0] rs_head,
  input logic [IDX_W-1:0] rs_tail,
  input logic             msi_pulse
);
  p_ro_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && addr_lo == 12'h0 && !dev_req_consume) |=> $stable(rq_head));

  p_ro_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && addr_lo == 12'hC && !dev_rsp_insert) |=> $stable(rs_tail));

  p_consume_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_consume && req_avail) |=> (rq_head == $past(rq_head) + IDX_W'(1)));

  p_consume_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_avail) |=> $stable(rq_head));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_full |=> $stable(rs_tail));

  p_msi_on_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_insert && !rsp_full && rs_head == rs_tail) |=> msi_pulse);

  p_msi_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past((dev_rsp_insert && !rsp_full && rs_head == rs_tail) ||
                        (dev_req_done && dev_done_force && cfg_force_en)));

  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_done && dev_done_force && cfg_force_en) |=> msi_pulse);
endmodule

bind qpair_ptr_regs qpair_ptr_regs_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .addr_lo(12'(bus_addr)),
  .dev_req_consume(dev_req_consume), .dev_rsp_insert(dev_rsp_insert),
  .dev_req_done(dev_req_done), .dev_done_force(dev_done_force),
  .cfg_force_en(cfg_force_en), .req_avail(req_avail), .rsp_full(rsp_full),
  .rq_head(rq_head), .rs_head(rs_head), .rs_tail(rs_tail), .msi_pulse(msi_pulse)
);

// File: tb/qpair_ptr_regs_tb.sv
`timescale 1ns/1ps
module qpair_ptr_regs_tb;
  localparam int DEPTH = 4;
  localparam int ES    = 32;
  localparam int AW    = 32;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [AW-1:0] req_base = 32'h1000, rsp_base = 32'h8000;
  logic dev_req_consume = 0, dev_rsp_insert = 0, dev_req_done = 0;
  logic dev_done_force = 0, cfg_force_en = 0;
  logic req_avail, rsp_full, msi_pulse;
  logic [AW-1:0] req_head_addr, rsp_tail_addr;
  int errs = 0, checks = 0;
  int mh, mt;

  always #2 clk = ~clk;

  qpair_ptr_regs #(.DEPTH(DEPTH), .ELEM_BYTES(ES), .AW(AW), .OFS_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_base(req_base), .rsp_base(rsp_base),
    .dev_req_consume(dev_req_consume), .dev_rsp_insert(dev_rsp_insert),
    .dev_req_done(dev_req_done), .dev_done_force(dev_done_force),
    .cfg_force_en(cfg_force_en), .req_avail(req_avail), .rsp_full(rsp_full),
    .req_head_addr(req_head_addr), .rsp_tail_addr(rsp_tail_addr),
    .msi_pulse(msi_pulse));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic hread(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_sel = 1; bus_wr = 0; bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 0; #1;
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    hread("R1 rqh", 12'h0, 0); hread("R1 rqt", 12'h4, 0);
    hread("R1 rsh", 12'h8, 0); hread("R1 rst", 12'hC, 0);
    chk("R1 msi", 32'(msi_pulse), 0); chk("R1 full", 32'(rsp_full), 0);
    chk("R1 avail", 32'(req_avail), 0);
    // R2 sweep of tail writes, wrapping modulo depth
    for (int v = 0; v < 2*DEPTH+1; v++) begin
      hwrite(12'h4, 32'(v) | 32'hABC0_0000);
      hread("R2 rqt", 12'h4, 32'(v % DEPTH));
      chk("R2 avail", 32'(req_avail), 32'((v % DEPTH) != 0));
    end
    // R3 read-only pointers
    hwrite(12'h0, 3); hread("R3 rqh", 12'h0, 0);
    hwrite(12'hC, 2); hread("R3 rst", 12'hC, 0);
    // R4 consume until empty and beyond
    hwrite(12'h4, 3);
    mh = 0;
    for (int i = 0; i < 5; i++) begin
      dev_req_consume = 1; tick(); dev_req_consume = 0;
      if (mh != 3) mh++;
      hread("R4 rqh", 12'h0, 32'(mh));
      chk("R9 req addr", req_head_addr, 32'h1000 + 32'(mh*ES));
    end
    chk("R4 avail", 32'(req_avail), 0);
    // R10 undefined offsets and unselected reads
    hread("R10 0x10", 12'h010, 0); hread("R10 0x2", 12'h002, 0);
    hread("R10 0xFFC", 12'hFFC, 0);
    bus_addr = 12'h4; #1; chk("R10 nosel", bus_rdata, 0);
    // R6/R7 fill response ring
    mt = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      dev_rsp_insert = 1; tick(); dev_rsp_insert = 0;
      chk("R7 msi", 32'(msi_pulse), 32'(i == 0));
      if (mt < DEPTH-1) mt++;
      hread("R6 rst", 12'hC, 32'(mt));
      chk("R9 rsp addr", rsp_tail_addr, 32'h8000 + 32'(mt*ES));
      chk("R6 full", 32'(rsp_full), 32'(mt == DEPTH-1));
      tick(); chk("R7 msi clear", 32'(msi_pulse), 0);
    end
    // R5 host drains
    hwrite(12'h8, 32'h10 + 3); hread("R5 rsh", 12'h8, 3);
    chk("R5 full", 32'(rsp_full), 0);
    // R11 insert into empty with simultaneous head rewrite: one pulse
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h8; bus_wdata = 3; dev_rsp_insert = 1;
    tick(); bus_sel = 0; bus_wr = 0; dev_rsp_insert = 0;
    chk("R11 pulse", 32'(msi_pulse), 1);
    tick(); chk("R11 single", 32'(msi_pulse), 0);
    hread("R11 rst", 12'hC, 0);
    // R11 insert into non-empty while host drains: no pulse
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h8; bus_wdata = 0; dev_rsp_insert = 1;
    tick(); bus_sel = 0; bus_wr = 0; dev_rsp_insert = 0;
    chk("R11 nopulse", 32'(msi_pulse), 0);
    hread("R11 rst2", 12'hC, 1); hread("R11 rsh2", 12'h8, 0);
    // R8 forced completion, all flag combinations
    for (int k = 0; k < 4; k++) begin
      dev_req_done = 1; dev_done_force = k[0]; cfg_force_en = k[1];
      tick(); dev_req_done = 0; dev_done_force = 0; cfg_force_en = 0;
      chk("R8 force", 32'(msi_pulse), 32'(k == 3));
      tick();
    end
    cfg_force_en = 1; dev_done_force = 1; tick(); cfg_force_en = 0; dev_done_force = 0;
    chk("R8 no done", 32'(msi_pulse), 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule